// File: doc/BRIEF.md
# Reset Pin Source Discriminator

This block owns a shared, active-low reset pad. Any party may pull the pad low: an off-chip supervisor, or this block itself through an open-drain pull-down. Whenever the pad reads low or a fault input is high, the core reset output goes high at once. This path is combinational and needs no clock. The core reset is removed only on a clock edge, after the pad level has passed through a synchronizer.

A watchdog expiry or a clock-monitor failure starts a discrimination sequence. The block pulls the pad low for a fixed number of cycles and then releases it. It waits a further fixed number of cycles and reads the synchronized pad level.
- If the pad has come back high, the fault alone caused the reset, and the block reports the code of that fault.
- If the pad is still held low, an external source is also holding reset, and the block reports the external code.

The CPU uses the reported code to choose which start-up vector to fetch.

The controller has four states:
- `ST_HOLD`: externally held reset.
- `ST_RUN`: reset released.
- `ST_PULL`: driving the pad low.
- `ST_SETTLE`: waiting for the sample point.

It has these transitions:
- HOLD→RUN when the synchronized pad reads high.
- RUN→PULL on either fault.
- PULL→SETTLE when the drive count ends.
- SETTLE→RUN when the pad samples high.
- SETTLE→HOLD when the pad samples low.
- From RUN or HOLD, any low pad level forces the block asynchronously into HOLD. In PULL and SETTLE this path is shielded, because the block drives the pad low itself in those states.

Top module: `rst_src_discrim`

## Requirements
- R1: While the pad is held low from outside the block (outside a discrimination sequence), `core_rst_o` is 1, `pin_pull_o` is 0 and `vec_sel_o` is 00.
- R2: `core_rst_o` rises without any clock edge when the pad goes low or when `wdog_trip_i` or `clk_fail_i` goes high.
- R3: After the pad returns high, `core_rst_o` stays 1 for two more rising edges and falls on the third. This is two synchronizer stages plus the state register.
- R4: A fault seen in the running state raises `pin_pull_o` from the next rising edge onward, for exactly 16 clock cycles.
- R5: The pad is sampled 8 cycles after the pull-down ends. If it reads high, `core_rst_o` falls on that same edge and `vec_sel_o` takes the fault code.
- R6: If the pad is low at the sample point, `vec_sel_o` becomes 00 and `core_rst_o` stays 1 until the pad is released. Release then follows R3.
- R7: `vec_sel_o` encoding: 00 external, 01 watchdog, 10 clock monitor; 11 never appears.
- R8: When both faults are seen in the same cycle, the clock-monitor code 10 is reported.
- R9: While the core is running, `vec_sel_o` does not change.
- R10: An external low pulse of 32 cycles or more that overlaps a discrimination sequence yields code 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| pin_n_i | input | 1 | Level read back from the reset pad (low = reset) |
| wdog_trip_i | input | 1 | Watchdog expiry |
| clk_fail_i | input | 1 | Clock-monitor failure |
| pin_pull_o | output | 1 | Enable for the open-drain pull-down on the pad |
| core_rst_o | output | 1 | Active-high reset to the core |
| vec_sel_o | output | 2 | Start-up vector code |

## Verification
The checks assume the pad behaves as a wired-AND: it is low whenever `pin_pull_o` is high or an outside source pulls it. The bench models the pad exactly this way.

Fault inputs are assumed to be short pulses that appear only while the core is running. They are also assumed never to coincide with the first cycle of an outside pull, since the asynchronous path would hide such a fault. The stimulus applies each fault for one cycle and starts any overlapping outside pulse at least one cycle after the fault. Every pulse stays inside those limits.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'b00,
        ST_RUN    = 2'b01,
        ST_PULL   = 2'b10,
        ST_SETTLE = 2'b11
    } rsd_state_e;

    typedef enum logic [1:0] {
        VEC_EXT  = 2'b00,
        VEC_WDOG = 2'b01,
        VEC_CMON = 2'b10
    } rsd_vec_e;

endpackage

// File: rtl/rsd_sync.sv
module rsd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or posedge arst) begin
                if (arst)
                    chain[i] <= 1'b0;
                else if (i == 0)
                    chain[i] <= d;
                else
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rsd_timer.sv
module rsd_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         arst,
    input  logic         clr,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or posedge arst) begin
        if (arst)
            count <= '0;
        else if (clr)
            count <= '0;
        else
            count <= count + 1'b1;
    end
endmodule

// File: rtl/rst_src_discrim.sv
module rst_src_discrim
    import rsd_pkg::*;
#(
    parameter int DRIVE_CYC   = 16,
    parameter int SETTLE_CYC  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       pin_n_i,
    input  logic       wdog_trip_i,
    input  logic       clk_fail_i,
    output logic       pin_pull_o,
    output logic       core_rst_o,
    output logic [1:0] vec_sel_o
);
    localparam int MAX_CYC = (DRIVE_CYC > SETTLE_CYC) ? DRIVE_CYC : SETTLE_CYC;
    localparam int CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    rsd_state_e state_q, state_d;
    rsd_vec_e   cause_q, vec_q;
    logic       shield, arst_req, pin_sync;
    logic       tmr_clr, drive_done, settle_done;
    logic [CW-1:0] cnt;

    // own pull-down must not reset the sequencer that drives it
    assign shield   = (state_q == ST_PULL) || (state_q == ST_SETTLE);
    assign arst_req = ~pin_n_i & ~shield;

    rsd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .arst (arst_req),
        .d    (pin_n_i),
        .q    (pin_sync)
    );

    assign tmr_clr = (state_d != state_q) || !shield;

    rsd_timer #(.W(CW)) u_timer (
        .clk   (clk),
        .arst  (arst_req),
        .clr   (tmr_clr),
        .count (cnt)
    );

    assign drive_done  = (state_q == ST_PULL)   && (cnt == CW'(DRIVE_CYC - 1));
    assign settle_done = (state_q == ST_SETTLE) && (cnt == CW'(SETTLE_CYC - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:   if (pin_sync) state_d = ST_RUN;
            ST_RUN:    if (wdog_trip_i || clk_fail_i) state_d = ST_PULL;
            ST_PULL:   if (drive_done) state_d = ST_SETTLE;
            ST_SETTLE: if (settle_done) state_d = pin_sync ? ST_RUN : ST_HOLD;
        endcase
    end

    // state register: asynchronous entry to HOLD, clocked exit
    always_ff @(posedge clk or posedge arst_req) begin
        if (arst_req)
            state_q <= ST_HOLD;
        else
            state_q <= state_d;
    end

    // fault cause and reported vector
    always_ff @(posedge clk or posedge arst_req) begin
        if (arst_req) begin
            cause_q <= VEC_EXT;
            vec_q   <= VEC_EXT;
        end else begin
            if (state_q == ST_RUN && (wdog_trip_i || clk_fail_i))
                cause_q <= clk_fail_i ? VEC_CMON : VEC_WDOG;
            if (settle_done)
                vec_q <= pin_sync ? cause_q : VEC_EXT;
        end
    end

    // outputs
    always_comb begin
        pin_pull_o = (state_q == ST_PULL);
        core_rst_o = (state_q != ST_RUN) | ~pin_n_i | wdog_trip_i | clk_fail_i;
        vec_sel_o  = vec_q;
    end
endmodule

// File: rtl/rst_src_discrim_chk.sv
module rst_src_discrim_chk #(
    parameter int DRIVE_CYC = 16
) (
    input logic       clk,
    input logic       arst_req,
    input logic       pin_n_i,
    input logic       wdog_trip_i,
    input logic       clk_fail_i,
    input logic       pin_pull_o,
    input logic       core_rst_o,
    input logic [1:0] vec_sel_o
);
    localparam int RW = $clog2(DRIVE_CYC + 2);

    logic [RW-1:0] pull_run = '0;

    always_ff @(posedge clk) begin
        if (pin_pull_o)
            pull_run <= pull_run + 1'b1;
        else
            pull_run <= '0;
    end

    p_pull_len_r4: assert property (@(posedge clk) disable iff (arst_req)
        $fell(pin_pull_o) |-> (pull_run == RW'(DRIVE_CYC)));

    p_pull_cap_r4: assert property (@(posedge clk) disable iff (arst_req)
        pin_pull_o |-> (pull_run < RW'(DRIVE_CYC)));

    p_pull_in_rst_r4: assert property (@(posedge clk) disable iff (arst_req)
        pin_pull_o |-> core_rst_o);

    p_vec_legal_r7: assert property (@(posedge clk) disable iff (arst_req)
        vec_sel_o != 2'b11);

    p_fault_rst_r2: assert property (@(posedge clk) disable iff (arst_req)
        (wdog_trip_i || clk_fail_i) |-> core_rst_o);

    p_pin_rst_r2: assert property (@(posedge clk) disable iff (pin_pull_o)
        !pin_n_i |-> core_rst_o);

    p_vec_hold_r9: assert property (@(posedge clk) disable iff (arst_req)
        (!core_rst_o && $past(!core_rst_o)) |-> $stable(vec_sel_o));
endmodule

bind rst_src_discrim rst_src_discrim_chk #(.DRIVE_CYC(DRIVE_CYC)) u_chk (
    .clk         (clk),
    .arst_req    (arst_req),
    .pin_n_i     (pin_n_i),
    .wdog_trip_i (wdog_trip_i),
    .clk_fail_i  (clk_fail_i),
    .pin_pull_o  (pin_pull_o),
    .core_rst_o  (core_rst_o),
    .vec_sel_o   (vec_sel_o)
);

// File: tb/rst_src_discrim_test.sv
`timescale 1ns/1ps
module rst_src_discrim_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic ext_low = 1'b1, wdog = 1'b0, cfail = 1'b0;
    logic pin_n, pull, rst;
    logic [1:0] vec;
    int cyc = 0, checks = 0, fails = 0;
    bit done = 1'b0;

    assign pin_n = ~(ext_low | pull);

    rst_src_discrim uut (
        .clk(clk), .pin_n_i(pin_n), .wdog_trip_i(wdog), .clk_fail_i(cfail),
        .pin_pull_o(pull), .core_rst_o(rst), .vec_sel_o(vec)
    );

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int at; string req; logic r; logic p; logic [1:0] v;
    } item_t;
    item_t q[$];

    task automatic chk(string req, logic r, logic p, logic [1:0] v);
        checks++;
        if (rst !== r || pull !== p || vec !== v) begin
            fails++;
            $display("FAIL %s cyc=%0d actual rst=%b pull=%b vec=%b expected rst=%b pull=%b vec=%b",
                     req, cyc, rst, pull, vec, r, p, v);
        end
    endtask

    task automatic push(int dly, string req, logic r, logic p, logic [1:0] v);
        q.push_back('{cyc + dly, req, r, p, v});
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // monitor: compares expected items as their cycle arrives
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            item_t it;
            it = q.pop_front();
            chk(it.req, it.r, it.p, it.v);
        end
    end

    // standard fault sequence expectations, fault applied at current cycle
    task automatic expect_seq(logic [1:0] v, string req);
        push(1,  "R4", 1'b1, 1'b1, 2'b00 | (vec & 2'b00) | prev_vec);
        push(16, "R4", 1'b1, 1'b1, prev_vec);
        push(17, "R4", 1'b1, 1'b0, prev_vec);
        push(24, "R5", 1'b1, 1'b0, prev_vec);
        push(25, req,  1'b0, 1'b0, v);
    endtask

    logic [1:0] prev_vec = 2'b00;

    initial begin
        // R1: held by outside source from time zero
        tick(5);
        chk("R1", 1'b1, 1'b0, 2'b00);
        // R3: release
        ext_low = 1'b0;
        push(2, "R3", 1'b1, 1'b0, 2'b00);
        push(3, "R3", 1'b0, 1'b0, 2'b00);
        tick(6);

        // watchdog fault, R2 async, R4/R5/R7 vector 01
        wdog = 1'b1;
        #0.5 chk("R2", 1'b1, 1'b0, 2'b00);
        prev_vec = 2'b00;
        expect_seq(2'b01, "R7");
        tick(1); wdog = 1'b0;
        tick(30);
        // R9: vector held while running
        push(5, "R9", 1'b0, 1'b0, 2'b01);
        tick(8);

        // clock-monitor fault
        cfail = 1'b1;
        #0.5 chk("R2", 1'b1, 1'b0, 2'b01);
        prev_vec = 2'b01;
        expect_seq(2'b10, "R7");
        tick(1); cfail = 1'b0;
        tick(30);

        // both faults same cycle, first a watchdog to move vector to 01
        wdog = 1'b1;
        prev_vec = 2'b10;
        expect_seq(2'b01, "R5");
        tick(1); wdog = 1'b0;
        tick(30);
        wdog = 1'b1; cfail = 1'b1;
        prev_vec = 2'b01;
        expect_seq(2'b10, "R8");
        tick(1); wdog = 1'b0; cfail = 1'b0;
        tick(30);

        // outside pull that ends before the sample point: fault code kept
        wdog = 1'b1;
        prev_vec = 2'b10;
        push(25, "R5", 1'b0, 1'b0, 2'b01);
        tick(1); wdog = 1'b0;
        tick(4); ext_low = 1'b1;
        tick(15); ext_low = 1'b0;
        tick(15);

        // 32-cycle outside pulse overlapping the sequence: external code
        cfail = 1'b1;
        push(1,  "R4", 1'b1, 1'b1, 2'b01);
        push(16, "R4", 1'b1, 1'b1, 2'b01);
        push(25, "R6", 1'b1, 1'b0, 2'b00);
        push(35, "R10", 1'b1, 1'b0, 2'b00);
        push(36, "R10", 1'b0, 1'b0, 2'b00);
        tick(1); cfail = 1'b0; ext_low = 1'b1;
        tick(32); ext_low = 1'b0;
        tick(10);

        // clock-monitor fault, then outside reset while running
        cfail = 1'b1;
        prev_vec = 2'b00;
        expect_seq(2'b10, "R5");
        tick(1); cfail = 1'b0;
        tick(30);
        ext_low = 1'b1;
        #0.5 chk("R2", 1'b1, 1'b0, 2'b00);
        tick(3);
        chk("R1", 1'b1, 1'b0, 2'b00);
        ext_low = 1'b0;
        push(2, "R3", 1'b1, 1'b0, 2'b00);
        push(3, "R3", 1'b0, 1'b0, 2'b00);
        tick(6);

        wait (q.size() == 0);
        tick(1);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog cyc=%0d actual running expected finished", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule